// File: doc/BRIEF.md
# Interrupt Source Enable and Status Register

This block gathers up to eight edge-triggered event inputs behind a single byte-wide register. A write to that register loads the enable mask. A read returns the sources that are enabled and have caught a rising edge since they were last enabled. One registered, level-sensitive interrupt line stays high while any enabled source is pending. A build-time mask decides which source positions exist. Absent positions can never be enabled, never pend and always read as zero.

The block has no write-one-to-clear acknowledge. To acknowledge a source, software clears its enable bit, which also discards its latched event, and then sets the bit again to re-arm it. The service routine reads the status, disables every pending source it sees and reads again. It repeats this, ignoring sources already handled, until the status reads zero. It then writes the full enable mask back. Each input passes through a two-flop synchroniser before edge detection, so asynchronous sources can be wired directly to the block.

Top module: `irq_src_ctrl`

## Requirements
- R1: After reset, the enable mask and every pending bit are 0, the interrupt output is low and read data is 0.
- R2: A write strobe at register address 0x1E loads the enable mask from the write data, with bits outside the valid mask forced to 0. Writes to any other address change nothing.
- R3: A read strobe at address 0x1E returns the pending bits on the read data bus one clock after the strobe, and bits outside the valid mask read 0. A read at any other address returns 0.
- R4: A rising edge on an enabled source sets its pending bit, two clocks after the synchroniser captures it. The bit stays set after the source falls again.
- R5: A rising edge on a source whose enable bit is 0 is lost. Enabling the source afterwards does not show it as pending.
- R6: Writing 0 to a source's enable bit clears that source's pending bit. Pending bits of sources that stay enabled are not changed by the write.
- R7: An edge that reaches the edge detector in the same clock as a write clearing that source's enable bit is dropped.
- R8: The interrupt output is registered. It is high exactly one clock after any pending bit is set, and it goes low one clock after the last pending bit clears.
- R9: A source that was acknowledged and then re-enabled latches its next rising edge again.
- R10: A source position outside the valid mask (bit 6 with the default mask 0xBF) never pends and never raises the interrupt, even when written as enabled.
- R11: A source held high through acknowledge and re-enable does not pend again until it produces a new rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | NSRC | Write data (enable mask) |
| bus_rdata | output | NSRC | Registered read data (pending status) |
| src_in | input | NSRC | Asynchronous event inputs |
| irq_out | output | 1 | Registered interrupt request |

## Verification
A table of enable masks paired with source patterns exercises the main function. The patterns include a single enabled source, edges that arrive only on disabled sources, an edge on the absent position, and masks that overlap the sources only in part. Together they separate "enabled and edged" from "edged only" and from "enabled only". After each pattern, the ack write shows whether the interrupt drops one clock late. Directed tests then cover a partial acknowledge, an edge landing in the same clock as its disable write, a source held high across a re-arm, and accesses at a neighbouring address. These tests separate a correct acknowledge from write-one-to-clear and level-triggered variants.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;
  typedef struct packed {
    logic wr_hit;
    logic rd_hit;
  } bus_dec_t;

  function automatic bus_dec_t decode(input logic wr, input logic rd, input logic match);
    bus_dec_t d;
    d.wr_hit = wr & match;
    d.rd_hit = rd & match;
    return d;
  endfunction
endpackage

// File: rtl/irq_src_sync.sv
module irq_src_sync #(
  parameter int unsigned NSRC = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] async_in,
  output logic [NSRC-1:0] rise
);
  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    logic meta_q, sync_q, prev_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= async_in[i];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end
    assign rise[i] = sync_q & ~prev_q;
  end
endmodule

// File: rtl/irq_src_latch.sv
module irq_src_latch #(
  parameter int unsigned NSRC = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] rise,
  input  logic [NSRC-1:0] en_cur,
  input  logic            wr_hit,
  input  logic [NSRC-1:0] en_next,
  output logic [NSRC-1:0] pend
);
  logic [NSRC-1:0] keep;

  // A bit survives only if it is enabled after this cycle's write.
  assign keep = wr_hit ? en_next : en_cur;

  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= keep & (pend | (rise & en_cur));
  end
endmodule

// File: rtl/irq_src_regif.sv
module irq_src_regif
  import irq_src_pkg::*;
#(
  parameter int unsigned       NSRC     = 8,
  parameter int unsigned       ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h1E,
  parameter logic [NSRC-1:0]   VALID    = 8'hBF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [NSRC-1:0]   wdata,
  input  logic [NSRC-1:0]   status,
  output logic [NSRC-1:0]   en_q,
  output logic              wr_hit,
  output logic [NSRC-1:0]   en_next,
  output logic [NSRC-1:0]   rdata
);
  bus_dec_t dec;

  assign dec     = decode(wr, rd, addr == REG_ADDR);
  assign wr_hit  = dec.wr_hit;
  assign en_next = wdata & VALID;

  always_ff @(posedge clk) begin
    if (rst)         en_q <= '0;
    else if (wr_hit) en_q <= en_next;
  end

  always_ff @(posedge clk) begin
    if (rst)             rdata <= '0;
    else if (dec.rd_hit) rdata <= status & VALID;
    else                 rdata <= '0;
  end
endmodule

// File: rtl/irq_src_ctrl.sv
module irq_src_ctrl #(
  parameter int unsigned       NSRC       = 8,
  parameter int unsigned       ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR   = 8'h1E,
  parameter logic [NSRC-1:0]   VALID_MASK = 8'hBF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [NSRC-1:0]   bus_wdata,
  output logic [NSRC-1:0]   bus_rdata,
  input  logic [NSRC-1:0]   src_in,
  output logic              irq_out
);
  logic [NSRC-1:0] rise_w;
  logic [NSRC-1:0] en_q;
  logic [NSRC-1:0] en_next;
  logic [NSRC-1:0] pend_q;
  logic            wr_hit;

  irq_src_sync #(.NSRC(NSRC)) u_sync (
    .clk(clk), .rst(rst), .async_in(src_in), .rise(rise_w)
  );

  irq_src_regif #(
    .NSRC(NSRC), .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .VALID(VALID_MASK)
  ) u_regif (
    .clk(clk), .rst(rst), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .wdata(bus_wdata), .status(pend_q), .en_q(en_q), .wr_hit(wr_hit),
    .en_next(en_next), .rdata(bus_rdata)
  );

  irq_src_latch #(.NSRC(NSRC)) u_latch (
    .clk(clk), .rst(rst), .rise(rise_w), .en_cur(en_q),
    .wr_hit(wr_hit), .en_next(en_next), .pend(pend_q)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_out <= 1'b0;
    else     irq_out <= |(pend_q & en_q & VALID_MASK);
  end
endmodule

// File: rtl/irq_src_ctrl_chk.sv
module irq_src_ctrl_chk #(
  parameter int unsigned     NSRC  = 8,
  parameter logic [NSRC-1:0] VALID = 8'hBF
) (
  input logic            clk,
  input logic            rst,
  input logic            wr_hit,
  input logic [NSRC-1:0] bus_wdata,
  input logic [NSRC-1:0] bus_rdata,
  input logic [NSRC-1:0] pend,
  input logic [NSRC-1:0] en,
  input logic [NSRC-1:0] rise,
  input logic            irq_out
);
  // R6
  ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> ((pend & ~$past(bus_wdata)) == '0));

  // R10
  valid_only_chk: assert property (@(posedge clk) disable iff (rst)
    (pend & ~VALID) == '0);

  // R4
  pend_needs_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (pend & ~$past(pend) & ~$past(rise)) == '0);

  // R5
  pend_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    (pend & ~$past(pend) & ~$past(en)) == '0);

  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(|$past(pend)) |-> !irq_out);

  // R8
  irq_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (|$past(pend)) |-> irq_out);

  // R3
  rdata_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rdata & ~VALID) == '0);
endmodule

bind irq_src_ctrl irq_src_ctrl_chk #(.NSRC(NSRC), .VALID(VALID_MASK)) u_chk (
  .clk(clk), .rst(rst), .wr_hit(wr_hit), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .pend(pend_q), .en(en_q), .rise(rise_w),
  .irq_out(irq_out)
);

// File: tb/irq_src_ctrl_bench.sv
module irq_src_ctrl_bench;
  localparam int unsigned NSRC  = 8;
  localparam logic [7:0]  REG   = 8'h1E;
  localparam logic [7:0]  OTHER = 8'h1D;
  localparam logic [7:0]  VALID = 8'hBF;

  // {enable mask, source pattern}
  localparam int NVEC = 6;
  localparam logic [15:0] VEC [NVEC] = '{
    16'hFF_01, 16'h0F_F0, 16'hFF_40, 16'hAA_FF, 16'h55_5A, 16'hC3_C3
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] bus_addr = '0;
  logic bus_wr = 1'b0;
  logic bus_rd = 1'b0;
  logic [NSRC-1:0] bus_wdata = '0;
  logic [NSRC-1:0] bus_rdata;
  logic [NSRC-1:0] src_in = '0;
  logic irq_out;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  irq_src_ctrl u_irq_src_ctrl (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_in(src_in), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse(input logic [7:0] m);
    @(negedge clk);
    src_in = src_in | m;
    repeat (4) @(negedge clk);
    src_in = src_in & ~m;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] r;
    logic [7:0] en, pat, exp;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", {7'd0, irq_out}, 8'h00);
    chk("R1 rdata", bus_rdata, 8'h00);
    rd_reg(REG, r);
    chk("R1 status", r, 8'h00);

    // Table walk: R2 R3 R4 R5 R8 R10
    for (int i = 0; i < NVEC; i++) begin
      en  = VEC[i][15:8];
      pat = VEC[i][7:0];
      exp = en & pat & VALID;
      wr_reg(REG, en);
      pulse(pat);
      rd_reg(REG, r);
      chk("R4 R5 R10 status", r, exp);
      chk("R8 irq level", {7'd0, irq_out}, {7'd0, |exp});
      wr_reg(REG, 8'h00);
      // write took effect at the edge before this sample; irq lags one clock
      chk("R8 irq registered lag", {7'd0, irq_out}, {7'd0, |exp});
      @(negedge clk);
      chk("R8 irq drop", {7'd0, irq_out}, 8'h00);
      rd_reg(REG, r);
      chk("R6 cleared", r, 8'h00);
    end

    // R5: edge while disabled, enable afterwards
    pulse(8'h04);
    wr_reg(REG, 8'h04);
    rd_reg(REG, r);
    chk("R5 late enable", r, 8'h00);

    // R6 partial acknowledge, R9 re-arm
    wr_reg(REG, 8'h03);
    pulse(8'h03);
    wr_reg(REG, 8'h02);
    rd_reg(REG, r);
    chk("R6 partial ack", r, 8'h02);
    chk("R6 irq kept", {7'd0, irq_out}, 8'h01);
    wr_reg(REG, 8'h03);
    pulse(8'h01);
    rd_reg(REG, r);
    chk("R9 rearm", r, 8'h03);
    wr_reg(REG, 8'h00);

    // R3 other address read returns 0 while pending
    wr_reg(REG, 8'h80);
    pulse(8'h80);
    rd_reg(OTHER, r);
    chk("R3 other read", r, 8'h00);
    rd_reg(REG, r);
    chk("R3 status read", r, 8'h80);
    wr_reg(REG, 8'h00);

    // R2 write to other address ignored
    wr_reg(OTHER, 8'hFF);
    pulse(8'h10);
    rd_reg(REG, r);
    chk("R2 other write", r, 8'h00);
    chk("R2 irq", {7'd0, irq_out}, 8'h00);

    // R10 invalid bit written as enabled
    wr_reg(REG, 8'h40);
    pulse(8'h40);
    rd_reg(REG, r);
    chk("R10 invalid bit", r, 8'h00);
    chk("R10 irq", {7'd0, irq_out}, 8'h00);

    // R7 edge in the same clock as the disable write
    wr_reg(REG, 8'h20);
    @(negedge clk);
    src_in = 8'h20;          // edge detector sees it at the third rising edge
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    bus_addr = REG; bus_wdata = 8'h00; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    src_in = 8'h00;
    repeat (3) @(negedge clk);
    wr_reg(REG, 8'h20);
    rd_reg(REG, r);
    chk("R7 dropped edge", r, 8'h00);
    wr_reg(REG, 8'h00);

    // R11 level held through ack and re-arm
    wr_reg(REG, 8'h08);
    @(negedge clk);
    src_in = 8'h08;
    repeat (5) @(negedge clk);
    wr_reg(REG, 8'h00);
    wr_reg(REG, 8'h08);
    repeat (4) @(negedge clk);
    rd_reg(REG, r);
    chk("R11 no retrigger", r, 8'h00);
    src_in = 8'h00;
    repeat (3) @(negedge clk);
    pulse(8'h08);
    rd_reg(REG, r);
    chk("R11 new edge", r, 8'h08);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule